// File: doc/BRIEF.md
# Serial Display Panel Bring-Up Sequencer

This block powers up a small display panel controller with no processor involved. A single start pulse begins the run. The block first cycles the panel's active-low reset line through a timed pulse. It then steps through a fixed table of 38 register writes. Each write goes out on a three-wire serial link (clock, data out and active-low select) as two separate 24-bit frames. The first frame names the register and the second carries the 16-bit value. Any table entry may ask for a pause, counted in milliseconds, before the next entry starts.

When the last entry has gone out, the block raises a panel-enable output, which stays high. It also gives a one-cycle completion pulse. The serial clock comes from the system clock through a parameterized divider. All pauses count a millisecond tick, which a parameterized prescaler makes from the system clock. The block only writes: it has no readback and no pixel data path.

Top module: `panel_init_seq`

## Requirements
- R1: Every transfer holds exactly 24 SCLK rising edges. CS_n goes low before the first edge and goes high only after the last falling edge.
- R2: SCLK rests low whenever CS_n is high. Data is sent most significant bit first. MOSI changes only together with a falling SCLK edge (or when CS_n falls), so it is stable across each high phase.
- R3: A register-index frame carries the bits 0x74, 0x00 and then the 8-bit register number, read from bit 23 down to bit 0.
- R4: A value frame carries the bits 0x76, then the high byte of the 16-bit value, then the low byte, read from bit 23 down to bit 0.
- R5: The 38 table entries go out in table order. Each entry sends its index frame and then its value frame. The first entry writes 0x0000 to register 0x07, and the last three write 0x0000 to registers 0x20, 0x21 and 0x22. An entry with no pause is followed by the next index frame in less than one millisecond tick.
- R6: After start, the panel reset line stays high for 100 ticks. It is then low for 20 ticks, then high for 20 more ticks before the first frame begins, each to within a few clock cycles of overhead. No frame is sent while reset is low.
- R7: An entry with a pause of N ms leaves at least N ticks, and at most N ticks plus 2*SCLK_HALF_DIV+8 cycles, between the end of its value frame and the next index frame. The table holds pauses of 10, 50, 200 and 30 ms.
- R8: Panel enable goes low when a run is accepted and stays low through the whole run. It goes high together with the completion pulse and then holds.
- R9: busy is high from the accepted start until completion. done is a single-cycle pulse at completion, with busy low in that cycle. A start in that same cycle is accepted and begins a new run.
- R10: A start pulse while busy is high has no effect: the frame stream, its timing and the number of completions are unchanged.
- R11: CS_n stays high for at least SCLK_HALF_DIV system clocks between two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; sampled only while idle |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the panel |
| cs_no | output | 1 | Active-low frame select |
| panel_rst_no | output | 1 | Active-low panel reset line |
| panel_en_o | output | 1 | Panel enable, high once the table completes |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. Busy has already dropped when done is raised, so a start held during that cycle must launch a fresh run at once. The bench raises start exactly while done is high and expects busy to be set on the next cycle. It then expects a second full run with correct reset timing and frame contents. A start pulse in the middle of a run is also checked: the frame stream and the completion count must be unchanged.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

   localparam int FRAME_BITS = 24;
   localparam int INIT_LEN   = 38;
   localparam logic [7:0] IDX_LEAD = 8'h74;
   localparam logic [7:0] VAL_LEAD = 8'h76;

   typedef struct packed {
      logic [7:0]  addr;
      logic [15:0] value;
      logic [7:0]  pause_ms;
   } init_step_t;

   function automatic init_step_t init_step(input int unsigned n);
      init_step_t s;
      case (n)
         0:  s = '{8'h07, 16'h0000, 8'd0};
         1:  s = '{8'h13, 16'h0000, 8'd10};
         2:  s = '{8'h11, 16'h3004, 8'd0};
         3:  s = '{8'h14, 16'h200F, 8'd0};
         4:  s = '{8'h10, 16'h1A20, 8'd0};
         5:  s = '{8'h13, 16'h0040, 8'd50};
         6:  s = '{8'h13, 16'h0060, 8'd0};
         7:  s = '{8'h13, 16'h0070, 8'd200};
         8:  s = '{8'h01, 16'h0127, 8'd0};
         9:  s = '{8'h02, 16'h0700, 8'd0};
         10: s = '{8'h03, 16'h1030, 8'd0};
         11: s = '{8'h08, 16'h0208, 8'd0};
         12: s = '{8'h0B, 16'h0620, 8'd0};
         13: s = '{8'h0C, 16'h0110, 8'd0};
         14: s = '{8'h30, 16'h0120, 8'd0};
         15: s = '{8'h31, 16'h0127, 8'd0};
         16: s = '{8'h32, 16'h0000, 8'd0};
         17: s = '{8'h33, 16'h0503, 8'd0};
         18: s = '{8'h34, 16'h0727, 8'd0};
         19: s = '{8'h35, 16'h0124, 8'd0};
         20: s = '{8'h36, 16'h0706, 8'd0};
         21: s = '{8'h37, 16'h0701, 8'd0};
         22: s = '{8'h38, 16'h0F00, 8'd0};
         23: s = '{8'h39, 16'h0F00, 8'd0};
         24: s = '{8'h40, 16'h0000, 8'd0};
         25: s = '{8'h41, 16'h0000, 8'd0};
         26: s = '{8'h42, 16'h013F, 8'd0};
         27: s = '{8'h43, 16'h0000, 8'd0};
         28: s = '{8'h44, 16'h013F, 8'd0};
         29: s = '{8'h45, 16'h0000, 8'd0};
         30: s = '{8'h46, 16'hEF00, 8'd0};
         31: s = '{8'h47, 16'h013F, 8'd0};
         32: s = '{8'h48, 16'h0000, 8'd0};
         33: s = '{8'h07, 16'h0015, 8'd30};
         34: s = '{8'h07, 16'h0017, 8'd0};
         35: s = '{8'h20, 16'h0000, 8'd0};
         36: s = '{8'h21, 16'h0000, 8'd0};
         37: s = '{8'h22, 16'h0000, 8'd0};
         default: s = '0;
      endcase
      return s;
   endfunction

   function automatic logic [FRAME_BITS-1:0] idx_word(input logic [7:0] addr);
      return {IDX_LEAD, 8'h00, addr};
   endfunction

   function automatic logic [FRAME_BITS-1:0] val_word(input logic [15:0] value);
      return {VAL_LEAD, value};
   endfunction

endpackage

// File: rtl/pis_frame_tx.sv
module pis_frame_tx #(
   parameter int HALF_DIV = 4,
   parameter int NBITS    = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic [NBITS-1:0] word_i,
   output logic             sclk_o,
   output logic             mosi_o,
   output logic             cs_no,
   output logic             fin_o
);
   localparam int CW = $clog2(HALF_DIV + 1);
   localparam int BW = $clog2(NBITS);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("pis_frame_tx: HALF_DIV must be at least 1");
   end
   if (NBITS < 2) begin : g_bad_bits
      $error("pis_frame_tx: NBITS must be at least 2");
   end

   typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_st_t;

   tx_st_t           st;
   logic [CW-1:0]    hcnt;
   logic [BW-1:0]    bcnt;
   logic [NBITS-1:0] shreg;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st    <= TX_IDLE;
         hcnt  <= '0;
         bcnt  <= '0;
         shreg <= '0;
         sclk_o <= 1'b0;
         cs_no <= 1'b1;
         fin_o <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         case (st)
            TX_IDLE: begin
               if (go_i) begin
                  shreg <= word_i;
                  cs_no <= 1'b0;
                  hcnt  <= '0;
                  bcnt  <= '0;
                  st    <= TX_SHIFT;
               end
            end
            TX_SHIFT: begin
               if (hcnt == CW'(HALF_DIV - 1)) begin
                  hcnt   <= '0;
                  sclk_o <= ~sclk_o;
                  if (sclk_o) begin
                     if (bcnt == BW'(NBITS - 1)) begin
                        cs_no <= 1'b1;
                        st    <= TX_GAP;
                     end else begin
                        shreg <= {shreg[NBITS-2:0], 1'b0};
                        bcnt  <= bcnt + 1'b1;
                     end
                  end
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            default: begin
               if (hcnt == CW'(HALF_DIV - 1)) begin
                  hcnt  <= '0;
                  fin_o <= 1'b1;
                  st    <= TX_IDLE;
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign mosi_o = shreg[NBITS-1] & ~cs_no;

endmodule

// File: rtl/pis_ms_timer.sv
module pis_ms_timer #(
   parameter int TICK_CYCLES = 200000,
   parameter int CNT_W       = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic [CNT_W-1:0] ms_i,
   output logic             fin_o
);
   localparam int PW = $clog2(TICK_CYCLES);

   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("pis_ms_timer: TICK_CYCLES must be at least 2");
   end

   logic             run;
   logic [PW-1:0]    pre;
   logic [CNT_W-1:0] rem;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run   <= 1'b0;
         pre   <= '0;
         rem   <= '0;
         fin_o <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (go_i) begin
            run <= 1'b1;
            pre <= '0;
            rem <= ms_i;
         end else if (run) begin
            if (pre == PW'(TICK_CYCLES - 1)) begin
               pre <= '0;
               if (rem <= CNT_W'(1)) begin
                  run   <= 1'b0;
                  fin_o <= 1'b1;
               end else begin
                  rem <= rem - 1'b1;
               end
            end else begin
               pre <= pre + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
   import panel_init_pkg::*;
#(
   parameter int SCLK_HALF_DIV  = 4,
   parameter int MS_TICK_CYCLES = 200000,
   parameter int RST_HIGH_MS    = 100,
   parameter int RST_LOW_MS     = 20,
   parameter int RST_SETTLE_MS  = 20,
   parameter int MS_W           = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic sclk_o,
   output logic mosi_o,
   output logic cs_no,
   output logic panel_rst_no,
   output logic panel_en_o,
   output logic busy_o,
   output logic done_o
);
   localparam int ENT_W  = $clog2(INIT_LEN);
   localparam int MS_MAX = (1 << MS_W) - 1;

   if (MS_W < 8) begin : g_bad_msw
      $error("panel_init_seq: MS_W must hold an 8-bit table pause");
   end
   if (RST_HIGH_MS < 1 || RST_HIGH_MS > MS_MAX ||
       RST_LOW_MS < 1 || RST_LOW_MS > MS_MAX ||
       RST_SETTLE_MS < 1 || RST_SETTLE_MS > MS_MAX) begin : g_bad_rst
      $error("panel_init_seq: reset phase lengths must lie in 1..2**MS_W-1");
   end

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_RHOLD, SQ_RLOW, SQ_RSETTLE, SQ_LAUNCH, SQ_IDX, SQ_VAL, SQ_PAUSE
   } sq_st_t;

   sq_st_t                 st;
   logic [ENT_W-1:0]       ent;
   logic                   tx_go;
   logic [FRAME_BITS-1:0]  tx_word;
   logic                   tx_fin;
   logic                   tm_go;
   logic [MS_W-1:0]        tm_ms;
   logic                   tm_fin;
   init_step_t             cur;

   assign cur = init_step(32'(ent));

   pis_frame_tx #(.HALF_DIV(SCLK_HALF_DIV), .NBITS(FRAME_BITS)) tx_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .go_i (tx_go), .word_i (tx_word),
      .sclk_o (sclk_o), .mosi_o (mosi_o), .cs_no (cs_no), .fin_o (tx_fin)
   );

   pis_ms_timer #(.TICK_CYCLES(MS_TICK_CYCLES), .CNT_W(MS_W)) tm_i (
      .clk_i (clk_i), .rst_ni (rst_ni), .go_i (tm_go), .ms_i (tm_ms),
      .fin_o (tm_fin)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st           <= SQ_IDLE;
         ent          <= '0;
         tx_go        <= 1'b0;
         tx_word      <= '0;
         tm_go        <= 1'b0;
         tm_ms        <= '0;
         panel_rst_no <= 1'b1;
         panel_en_o   <= 1'b0;
         done_o       <= 1'b0;
      end else begin
         tx_go  <= 1'b0;
         tm_go  <= 1'b0;
         done_o <= 1'b0;
         case (st)
            SQ_IDLE: if (start_i) begin
               panel_rst_no <= 1'b1;
               panel_en_o   <= 1'b0;
               ent          <= '0;
               tm_ms        <= MS_W'(RST_HIGH_MS);
               tm_go        <= 1'b1;
               st           <= SQ_RHOLD;
            end
            SQ_RHOLD: if (tm_fin) begin
               panel_rst_no <= 1'b0;
               tm_ms        <= MS_W'(RST_LOW_MS);
               tm_go        <= 1'b1;
               st           <= SQ_RLOW;
            end
            SQ_RLOW: if (tm_fin) begin
               panel_rst_no <= 1'b1;
               tm_ms        <= MS_W'(RST_SETTLE_MS);
               tm_go        <= 1'b1;
               st           <= SQ_RSETTLE;
            end
            SQ_RSETTLE: if (tm_fin) st <= SQ_LAUNCH;
            SQ_LAUNCH: begin
               tx_word <= idx_word(cur.addr);
               tx_go   <= 1'b1;
               st      <= SQ_IDX;
            end
            SQ_IDX: if (tx_fin) begin
               tx_word <= val_word(cur.value);
               tx_go   <= 1'b1;
               st      <= SQ_VAL;
            end
            SQ_VAL: if (tx_fin) begin
               if (cur.pause_ms != 8'd0) begin
                  tm_ms <= MS_W'(cur.pause_ms);
                  tm_go <= 1'b1;
                  st    <= SQ_PAUSE;
               end else if (ent == ENT_W'(INIT_LEN - 1)) begin
                  panel_en_o <= 1'b1;
                  done_o     <= 1'b1;
                  st         <= SQ_IDLE;
               end else begin
                  ent <= ent + 1'b1;
                  st  <= SQ_LAUNCH;
               end
            end
            default: if (tm_fin) begin
               if (ent == ENT_W'(INIT_LEN - 1)) begin
                  panel_en_o <= 1'b1;
                  done_o     <= 1'b1;
                  st         <= SQ_IDLE;
               end else begin
                  ent <= ent + 1'b1;
                  st  <= SQ_LAUNCH;
               end
            end
         endcase
      end
   end

   assign busy_o = (st != SQ_IDLE);

endmodule

// File: rtl/panel_init_seq_chk.sv
module panel_init_seq_chk #(
   parameter int NBITS = 24
) (
   input logic clk_i,
   input logic rst_ni,
   input logic sclk_o,
   input logic mosi_o,
   input logic cs_no,
   input logic panel_rst_no,
   input logic panel_en_o,
   input logic busy_o,
   input logic done_o
);
   logic       sclk_q;
   logic [7:0] rise_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_q   <= 1'b0;
         rise_cnt <= '0;
      end else begin
         sclk_q <= sclk_o;
         if (cs_no) rise_cnt <= '0;
         else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      end
   end

   assert_frame_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cs_no) |-> (rise_cnt == 8'(NBITS)));

   assert_sclk_rest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_no |-> !sclk_o);

   assert_mosi_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

   assert_quiet_in_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !panel_rst_no |-> cs_no);

   assert_enable_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (panel_en_o && !busy_o));

   assert_enable_low_in_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> !panel_en_o);

   assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_idle_no_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> cs_no);

   assert_cs_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cs_no) |=> cs_no);

endmodule

bind panel_init_seq panel_init_seq_chk #(.NBITS(panel_init_pkg::FRAME_BITS)) chk_i (
   .clk_i (clk_i), .rst_ni (rst_ni), .sclk_o (sclk_o), .mosi_o (mosi_o),
   .cs_no (cs_no), .panel_rst_no (panel_rst_no), .panel_en_o (panel_en_o),
   .busy_o (busy_o), .done_o (done_o)
);

// File: tb/panel_init_seq_tb.sv
`timescale 1ns/1ps
module panel_init_seq_tb_top;
   localparam int DIV  = 2;
   localparam int TK   = 16;
   localparam int NENT = 38;
   localparam int NFR  = 2 * NENT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sclk, mosi, cs_n, prst_n, pen, busy, done;

   always #2.5 clk = ~clk;

   panel_init_seq #(
      .SCLK_HALF_DIV(DIV), .MS_TICK_CYCLES(TK),
      .RST_HIGH_MS(100), .RST_LOW_MS(20), .RST_SETTLE_MS(20), .MS_W(8)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start), .sclk_o (sclk),
      .mosi_o (mosi), .cs_no (cs_n), .panel_rst_no (prst_n),
      .panel_en_o (pen), .busy_o (busy), .done_o (done)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // expected table: {addr, value, pause}
   function automatic logic [31:0] exp_step(input int n);
      case (n)
         0: return 32'h07_0000_00;  1: return 32'h13_0000_0A;
         2: return 32'h11_3004_00;  3: return 32'h14_200F_00;
         4: return 32'h10_1A20_00;  5: return 32'h13_0040_32;
         6: return 32'h13_0060_00;  7: return 32'h13_0070_C8;
         8: return 32'h01_0127_00;  9: return 32'h02_0700_00;
         10: return 32'h03_1030_00; 11: return 32'h08_0208_00;
         12: return 32'h0B_0620_00; 13: return 32'h0C_0110_00;
         14: return 32'h30_0120_00; 15: return 32'h31_0127_00;
         16: return 32'h32_0000_00; 17: return 32'h33_0503_00;
         18: return 32'h34_0727_00; 19: return 32'h35_0124_00;
         20: return 32'h36_0706_00; 21: return 32'h37_0701_00;
         22: return 32'h38_0F00_00; 23: return 32'h39_0F00_00;
         24: return 32'h40_0000_00; 25: return 32'h41_0000_00;
         26: return 32'h42_013F_00; 27: return 32'h43_0000_00;
         28: return 32'h44_013F_00; 29: return 32'h45_0000_00;
         30: return 32'h46_EF00_00; 31: return 32'h47_013F_00;
         32: return 32'h48_0000_00; 33: return 32'h07_0015_1E;
         34: return 32'h07_0017_00; 35: return 32'h20_0000_00;
         36: return 32'h21_0000_00; 37: return 32'h22_0000_00;
         default: return 32'h0;
      endcase
   endfunction

   // monitor, sampled on the falling clock edge
   int cyc = 0;
   logic [23:0] fr [256];
   int nb [256];
   int cf_t [256];
   int cr_t [256];
   int nf = 0;
   int bz_t [8];
   int nbz = 0;
   int rf_t [8];
   int nrf = 0;
   int rr_t [8];
   int nrr = 0;
   int dn_t [8];
   int nd = 0;
   int mosi_bad = 0, sclk_bad = 0, done_long = 0, en_bad = 0;
   logic [23:0] sh = '0;
   int nbit = 0;
   logic p_sclk = 0, p_cs = 1, p_busy = 0, p_rst = 1, p_done = 0, p_mosi = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (p_cs && !cs_n) begin
            if (nf < 256) cf_t[nf] = cyc;
            sh = '0; nbit = 0;
            if (pen) en_bad++;
         end
         if (!cs_n && sclk && !p_sclk) begin
            sh = {sh[22:0], mosi}; nbit++;
         end
         if (!p_cs && cs_n && nf < 256) begin
            fr[nf] = sh; nb[nf] = nbit; cr_t[nf] = cyc; nf++;
         end
         if (sclk && p_sclk && mosi != p_mosi) mosi_bad++;
         if (cs_n && sclk) sclk_bad++;
         if (!p_busy && busy && nbz < 8) begin bz_t[nbz] = cyc; nbz++; end
         if (p_rst && !prst_n && nrf < 8) begin rf_t[nrf] = cyc; nrf++; end
         if (!p_rst && prst_n && nrr < 8) begin rr_t[nrr] = cyc; nrr++; end
         if (done && nd < 8) begin dn_t[nd] = cyc; nd++; end
         if (done && p_done) done_long++;
      end
      p_sclk = sclk; p_cs = cs_n; p_busy = busy; p_rst = prst_n;
      p_done = done; p_mosi = mosi;
   end

   task automatic analyze(input int r);
      int b;
      b = r * NFR;
      chk(rf_t[r] - bz_t[r] >= 100*TK && rf_t[r] - bz_t[r] <= 100*TK + 6,
          "R6 reset high phase", rf_t[r] - bz_t[r], 100*TK);
      chk(rr_t[r] - rf_t[r] >= 20*TK && rr_t[r] - rf_t[r] <= 20*TK + 6,
          "R6 reset low phase", rr_t[r] - rf_t[r], 20*TK);
      chk(cf_t[b] - rr_t[r] >= 20*TK && cf_t[b] - rr_t[r] <= 20*TK + 8,
          "R6 settle before first frame", cf_t[b] - rr_t[r], 20*TK);
      for (int e = 0; e < NENT; e++) begin
         logic [31:0] x;
         int i, g, ms;
         x = exp_step(e);
         i = b + 2*e;
         ms = int'(x[7:0]);
         chk(nb[i] == 24, "R1 index frame length", nb[i], 24);
         chk(nb[i+1] == 24, "R1 value frame length", nb[i+1], 24);
         chk(fr[i] == {8'h74, 8'h00, x[31:24]}, "R3 index frame / R5 order",
             fr[i], {8'h74, 8'h00, x[31:24]});
         chk(fr[i+1] == {8'h76, x[23:8]}, "R4 value frame / R5 order",
             fr[i+1], {8'h76, x[23:8]});
         g = cf_t[i+1] - cr_t[i];
         chk(g >= DIV && g < TK, "R11 select gap", g, DIV);
         if (e < NENT - 1) begin
            g = cf_t[i+2] - cr_t[i+1];
            if (ms != 0)
               chk(g >= ms*TK && g <= ms*TK + 2*DIV + 8, "R7 entry pause", g, ms*TK);
            else
               chk(g >= DIV && g < TK, "R5 no pause between entries", g, DIV);
         end else begin
            g = dn_t[r] - cr_t[i+1];
            chk(g > 0 && g < TK, "R9 done after last frame", g, DIV);
         end
      end
   endtask

   task automatic pulse_start;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0, "R2 reset idle link", {cs_n, sclk}, 2'b10);
      chk(busy == 1'b0 && done == 1'b0, "R9 reset idle status", {busy, done}, 0);
      chk(pen == 1'b0 && prst_n == 1'b1, "R8 reset enable/reset line", {pen, prst_n}, 2'b01);

      // run 0 with a stray start in mid-run
      pulse_start();
      @(negedge clk);
      chk(busy == 1'b1 && pen == 1'b0, "R8 busy set, enable low", {busy, pen}, 2'b10);
      repeat (4000) @(posedge clk);
      pulse_start();
      wait (nd == 1);
      @(negedge clk);
      chk(busy == 1'b0 && pen == 1'b1, "R8 enable held after run", {busy, pen}, 2'b01);
      chk(nf == NFR, "R10 frame count with stray start", nf, NFR);
      chk(nbz == 1, "R10 start while busy ignored", nbz, 1);
      analyze(0);
      repeat (20) @(posedge clk);
      chk(nd == 1 && pen == 1'b1, "R10 single completion", nd, 1);

      // run 1, then start raised during the done cycle (run 2)
      pulse_start();
      @(negedge clk);
      while (done !== 1'b1) @(negedge clk);
      start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1 && pen == 1'b0, "R9 start in done cycle accepted", {busy, pen}, 2'b10);
      wait (nd == 3);
      @(negedge clk);
      chk(nf == 3*NFR, "R5 frame count over three runs", nf, 3*NFR);
      chk(nbz == 3, "R9 three accepted starts", nbz, 3);
      analyze(1);
      analyze(2);
      chk(mosi_bad == 0, "R2 MOSI stable in SCLK high", mosi_bad, 0);
      chk(sclk_bad == 0, "R2 SCLK low while deselected", sclk_bad, 0);
      chk(done_long == 0, "R9 done one cycle", done_long, 0);
      chk(en_bad == 0, "R8 enable low during frames", en_bad, 0);
      chk(pen == 1'b1, "R8 enable after final run", pen, 1);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule